// File: doc/BRIEF.md
# Bit-Serial Sliced Multiply-Accumulate Group

This block computes one dot product per job for a single weight group. Every row holds a stationary weight that is split across up to `COLS` slice columns. Each column stores a small slice per row, a width mode and a left-shift offset. Activations stream in one bit per accepted cycle, least significant bit first. In each accepted cycle, every row gates its slices with its activation bit. Each column adds up its gated slices across all rows, shifts that sum to the current bit position and adds it to its own accumulator. When the last of the `PREC` bits has been taken in, the column accumulators are shifted by their slice offsets, added together and registered as the group result.

Weight slices are loaded with a load strobe and stay fixed across any number of jobs. A job begins with a start pulse, which clears the accumulators and samples the activation signedness. Activation bits may arrive with idle cycles between them. A start pulse may come in the same cycle as the first bit of the job, and that cycle may also be the one in which the previous job's result is presented, so jobs can run back to back.

Top module: `bsmac_group`

## Requirements
- R1: While reset is held and in the cycle after it, `out_vld` is 0 and `out_sum` is 0.
- R2: A column whose wide bit is 1 uses its slice `ld_slices[3*(r*COLS+c)+:3]` as a 3-bit two's-complement operand, with values from -4 to 3.
- R3: A column whose wide bit is 0 uses only the slice's low two bits. When `ld_sext` is 1, these are read as a signed value from -2 to 1; when it is 0, they are read as an unsigned value from 0 to 3.
- R4: A column whose enable bit is 0 adds nothing to the result, whatever its slices hold.
- R5: Bits on `act_bits` (bit r belongs to row r) are taken LSB first, one per cycle in which `act_vld` is high during a job. `out_vld` pulses for one cycle, in the cycle after the `PREC`-th bit. `out_sum` then equals the sum over rows of A_r times W_r, where W_r is the sum over columns of operand(r,c) shifted left by `ld_off[OFFW*c+:OFFW]`.
- R6: If `act_signed` is 1 at the start pulse, each A_r is a two's-complement value: its last bit carries weight -2^(PREC-1). Otherwise A_r is unsigned.
- R7: A start pulse clears the accumulators. If `act_vld` is high in the same cycle, that bit is bit 0 of the new job. Such a cycle may coincide with the previous job's `out_vld` pulse.
- R8: `act_vld` outside a job (after reset and before any start, or after a job's last bit) is ignored. `out_vld` stays 0 and `out_sum` keeps its value.
- R9: `out_sum` changes only in cycles where `out_vld` is 1.
- R10: Idle cycles between activation bits of a job do not change the result.
- R11: The `ld` strobe captures the slices, modes, enables, offsets and `ld_sext`. They apply to all bits accepted after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Capture the weight configuration |
| ld_slices | input | ROWS*COLS*3 | Slice for row r, column c at [3*(r*COLS+c)+:3] |
| ld_wide | input | COLS | Per-column mode: 1 = 3-bit slice, 0 = 2-bit slice |
| ld_en | input | COLS | Per-column enable |
| ld_off | input | COLS*OFFW | Per-column left-shift offset |
| ld_sext | input | 1 | Sign-extend 2-bit slices |
| start | input | 1 | Begin a job, clear the accumulators |
| act_signed | input | 1 | Activations are two's-complement (sampled at start) |
| act_vld | input | 1 | An activation bit is present |
| act_bits | input | ROWS | One activation bit per row |
| out_vld | output | 1 | One-cycle pulse when the result is ready |
| out_sum | output | OW | Signed group result |

## Verification
Two functions can land in the same cycle. The first is the start of a new job together with its bit 0. The second is the presentation of the previous job's result. The bench provokes this collision by issuing start and the first bit in the very cycle in which it samples the previous `out_vld` pulse. It then judges both jobs against arithmetic expectations: the earlier result must be intact, and the later one must contain nothing carried over from it. The other collision the bench provokes is the arrival of the last bit of a signed job, whose bit is negated in that same cycle. It checks this across sweeps of random slice modes and offsets, and with idle gaps between bits.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;
  localparam int SLW = 3;

  // Turn a raw slice into the 3-bit signed operand held in a column.
  function automatic logic [SLW-1:0] slice_operand(
    input logic [SLW-1:0] raw,
    input logic           wide,
    input logic           en,
    input logic           sext
  );
    logic [SLW-1:0] op;
    if (!en)       op = '0;
    else if (wide) op = raw;
    else           op = {sext & raw[1], raw[1:0]};
    return op;
  endfunction
endpackage

// File: rtl/bsmac_seq.sv
module bsmac_seq #(
  parameter int PREC = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            act_vld,
  input  logic            act_signed,
  output logic            accept,
  output logic            last,
  output logic            neg,
  output logic [IDXW-1:0] idx
);
  logic [IDXW-1:0] idx_q;
  logic            busy_q;
  logic            sgn_q;
  logic            eff_sgn;

  always_comb begin
    idx     = start ? '0 : idx_q;
    accept  = act_vld & (start | busy_q);
    last    = accept & (idx == IDXW'(PREC-1));
    eff_sgn = start ? act_signed : sgn_q;
    neg     = eff_sgn & last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else begin
      if (start) sgn_q <= act_signed;
      if (accept) begin
        idx_q  <= last ? '0 : idx + IDXW'(1);
        busy_q <= ~last;
      end else if (start) begin
        idx_q  <= '0;
        busy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsmac_col.sv
module bsmac_col #(
  parameter int ROWS = 64,
  parameter int IDXW = 3,
  parameter int AW   = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 accept,
  input  logic                 neg,
  input  logic [IDXW-1:0]      idx,
  input  logic [ROWS-1:0]      act,
  input  logic [ROWS*3-1:0]    ops,
  output logic signed [AW-1:0] acc_nxt
);
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] csum;
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] base;

  always_comb begin
    csum = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (act[r]) csum = csum + {{(AW-3){ops[3*r+2]}}, ops[3*r +: 3]};
    end
    term = csum <<< idx;
    if (neg) term = -term;
    base    = clr ? '0 : acc_q;
    acc_nxt = accept ? base + term : base;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nxt;
  end
endmodule

// File: rtl/bsmac_group.sv
module bsmac_group
  import bsmac_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 4,
  parameter int PREC = 8,
  parameter int OFFW = 3,
  localparam int IDXW = (PREC > 1) ? $clog2(PREC) : 1,
  localparam int CSW  = $clog2(ROWS) + 3,
  localparam int AW   = CSW + PREC,
  localparam int OW   = AW + (2**OFFW) - 1 + $clog2(COLS) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld,
  input  logic [ROWS*COLS*3-1:0] ld_slices,
  input  logic [COLS-1:0]        ld_wide,
  input  logic [COLS-1:0]        ld_en,
  input  logic [COLS*OFFW-1:0]   ld_off,
  input  logic                   ld_sext,
  input  logic                   start,
  input  logic                   act_signed,
  input  logic                   act_vld,
  input  logic [ROWS-1:0]        act_bits,
  output logic                   out_vld,
  output logic [OW-1:0]          out_sum
);
  logic [ROWS*COLS*3-1:0] ops_q;
  logic [COLS*OFFW-1:0]   off_q;
  logic                   accept, last, neg;
  logic [IDXW-1:0]        idx;
  logic signed [AW-1:0]   acc_nxt [COLS];
  logic signed [OW-1:0]   gsum;

  // Stationary operands, decoded once at load time.
  always_ff @(posedge clk) begin
    if (rst) begin
      ops_q <= '0;
      off_q <= '0;
    end else if (ld) begin
      off_q <= ld_off;
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          ops_q[3*(r*COLS+c) +: 3] <= slice_operand(ld_slices[3*(r*COLS+c) +: 3],
                                                    ld_wide[c], ld_en[c], ld_sext);
        end
      end
    end
  end

  bsmac_seq #(.PREC(PREC), .IDXW(IDXW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .act_vld(act_vld),
    .act_signed(act_signed), .accept(accept), .last(last), .neg(neg), .idx(idx)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS*3-1:0] col_ops;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign col_ops[3*r +: 3] = ops_q[3*(r*COLS+c) +: 3];
    end
    bsmac_col #(.ROWS(ROWS), .IDXW(IDXW), .AW(AW)) u_col (
      .clk(clk), .rst(rst), .clr(start), .accept(accept), .neg(neg),
      .idx(idx), .act(act_bits), .ops(col_ops), .acc_nxt(acc_nxt[c])
    );
  end

  // Recombine the columns by their slice offsets.
  always_comb begin
    gsum = '0;
    for (int c = 0; c < COLS; c++) begin
      gsum = gsum + ({{(OW-AW){acc_nxt[c][AW-1]}}, acc_nxt[c]} <<< off_q[OFFW*c +: OFFW]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_sum <= '0;
    end else begin
      out_vld <= last;
      if (last) out_sum <= gsum;
    end
  end
endmodule

// File: rtl/bsmac_group_chk.sv
module bsmac_group_chk #(
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          act_vld,
  input logic          out_vld,
  input logic [OW-1:0] out_sum
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!out_vld && out_sum == '0));

  // R5
  vld_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(act_vld));

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R9
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_sum));

  // R7
  start_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !act_vld) |=> !out_vld);
endmodule

bind bsmac_group bsmac_group_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .act_vld(act_vld),
  .out_vld(out_vld), .out_sum(out_sum)
);

// File: tb/bsmac_group_tb.sv
module bsmac_group_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int PREC = 4;
  localparam int OFFW = 3;
  localparam int OW   = $clog2(ROWS) + 3 + PREC + (2**OFFW) - 1 + $clog2(COLS) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld = 1'b0;
  logic [ROWS*COLS*3-1:0] ld_slices = '0;
  logic [COLS-1:0] ld_wide = '0, ld_en = '0;
  logic [COLS*OFFW-1:0] ld_off = '0;
  logic ld_sext = 1'b0, start = 1'b0, act_signed = 1'b0, act_vld = 1'b0;
  logic [ROWS-1:0] act_bits = '0;
  logic out_vld;
  logic [OW-1:0] out_sum;

  always #2 clk = ~clk;

  bsmac_group #(.ROWS(ROWS), .COLS(COLS), .PREC(PREC), .OFFW(OFFW)) u_dut (
    .clk(clk), .rst(rst), .ld(ld), .ld_slices(ld_slices), .ld_wide(ld_wide),
    .ld_en(ld_en), .ld_off(ld_off), .ld_sext(ld_sext), .start(start),
    .act_signed(act_signed), .act_vld(act_vld), .act_bits(act_bits),
    .out_vld(out_vld), .out_sum(out_sum)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  int slc [ROWS][COLS];
  bit wide [COLS], en [COLS];
  int off [COLS];
  bit sext;

  function automatic int rnd(int m);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:16]) % m;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sum_val();
    return longint'($signed(out_sum));
  endfunction

  function automatic longint opval(int r, int c);
    int s = slc[r][c];
    int lo = s & 3;
    if (!en[c]) return 0;
    if (wide[c]) return (s >= 4) ? s - 8 : s;
    if (sext && lo >= 2) return lo - 4;
    return lo;
  endfunction

  task automatic load_cfg();
    @(negedge clk);
    for (int c = 0; c < COLS; c++) begin
      ld_wide[c] = wide[c];
      ld_en[c]   = en[c];
      ld_off[OFFW*c +: OFFW] = OFFW'(off[c]);
      for (int r = 0; r < ROWS; r++) ld_slices[3*(r*COLS+c) +: 3] = 3'(slc[r][c]);
    end
    ld_sext = sext;
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic rand_cfg();
    for (int c = 0; c < COLS; c++) begin
      wide[c] = rnd(2) == 1;
      en[c]   = rnd(5) != 0;
      off[c]  = rnd(8);
      for (int r = 0; r < ROWS; r++) slc[r][c] = rnd(8);
    end
    sext = rnd(2) == 1;
  endtask

  // Runs one job; on return the clock is at the negedge where out_vld is visible.
  task automatic run_job(string req, bit sgn, bit fused, int gap);
    logic [ROWS-1:0] a [PREC];
    longint exp, av, w;
    for (int k = 0; k < PREC; k++) a[k] = ROWS'(rnd(1 << ROWS));
    exp = 0;
    for (int r = 0; r < ROWS; r++) begin
      av = 0;
      for (int k = 0; k < PREC; k++) if (a[k][r]) av += (longint'(1) << k);
      if (sgn && a[PREC-1][r]) av -= (longint'(1) << PREC);
      w = 0;
      for (int c = 0; c < COLS; c++) w += opval(r, c) <<< off[c];
      exp += av * w;
    end
    act_signed = sgn;
    if (!fused) begin
      act_vld = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      act_signed = ~sgn;
    end
    for (int k = 0; k < PREC; k++) begin
      act_vld = 1'b1;
      act_bits = a[k];
      start = fused && (k == 0);
      @(negedge clk);
      start = 1'b0;
      act_signed = ~sgn;
      if (k < PREC - 1 && gap > 0) begin
        act_vld = 1'b0;
        act_bits = ~act_bits;
        repeat (gap) begin
          @(negedge clk);
          check(out_vld == 1'b0, "R10 early valid", longint'(out_vld), 0);
        end
      end
    end
    act_vld = 1'b0;
    check(out_vld == 1'b1, {req, " valid"}, longint'(out_vld), 1);
    check(sum_val() == exp, {req, " sum"}, sum_val(), exp);
  endtask

  task automatic stray_bits(string req);
    longint held = sum_val();
    for (int i = 0; i < 3; i++) begin
      act_vld = 1'b1;
      act_bits = ROWS'(rnd(1 << ROWS));
      @(negedge clk);
      check(out_vld == 1'b0, {req, " valid"}, longint'(out_vld), 0);
      check(sum_val() == held, {req, " held"}, sum_val(), held);
    end
    act_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R1 valid", longint'(out_vld), 0);
    check(out_sum == '0, "R1 sum", sum_val(), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0 && out_sum == '0, "R1 after", sum_val(), 0);

    // R8: bits before any start are ignored
    stray_bits("R8 idle");

    // R2 and R3: exhaustive slice values, one column, all rows equal
    for (int mode = 0; mode < 3; mode++) begin
      for (int s = 0; s < 8; s++) begin
        for (int c = 0; c < COLS; c++) begin
          wide[c] = (mode == 0);
          en[c] = (c == 0);
          off[c] = 0;
          for (int r = 0; r < ROWS; r++) slc[r][c] = s;
        end
        sext = (mode == 1);
        load_cfg();
        run_job(mode == 0 ? "R2" : "R3", 1'b0, 1'b0, 0);
        run_job(mode == 0 ? "R2 signed" : "R3 signed", 1'b1, 1'b0, 0);
      end
    end

    // R4: disabled columns with full slices
    for (int c = 0; c < COLS; c++) begin
      wide[c] = 1'b1;
      en[c] = (c != 1);
      off[c] = 2 * c;
      for (int r = 0; r < ROWS; r++) slc[r][c] = 7 - r;
    end
    sext = 1'b0;
    load_cfg();
    run_job("R4", 1'b0, 1'b0, 0);

    // R11: new configuration applies to the next job
    en[1] = 1'b1;
    load_cfg();
    run_job("R11", 1'b0, 1'b0, 0);

    // R8: bits after a finished job are ignored
    stray_bits("R8 post");

    // R6, R7, R10 and R5 sweeps over random configurations
    for (int i = 0; i < 60; i++) begin
      rand_cfg();
      load_cfg();
      run_job("R5", 1'b0, 1'b0, 0);
      run_job("R6", 1'b1, 1'b0, 0);
      run_job("R7 fused", 1'b0, 1'b1, 0);
      run_job("R7 fused signed", 1'b1, 1'b1, 0);
      run_job("R10 gaps", rnd(2) == 1, 1'b0, 1 + rnd(3));
      run_job("R10 fused gaps", rnd(2) == 1, 1'b1, 1 + rnd(2));
      @(negedge clk);
      check(out_vld == 1'b0, "R5 single pulse", longint'(out_vld), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule